// File: doc/BRIEF.md
# Indirect-Addressed Codec Control Front End

This block is the host-facing register front end of an audio codec. A host reaches it through four byte-wide ports on a simple synchronous bus: a pointer port, a window port, a status port and a reserved polled-data port. Behind the window port there is a bank of 32 eight-bit control registers. The host selects one of them by writing its number into the pointer port.

Around that bank the block does the housekeeping the codec needs. It holds a busy state after reset and during software power-down. It guards the data-format and interface-setup registers behind a mode-change enable bit, and mutes the DAC while that bit is set. It keeps the interrupt-active flag, and it gates the DMA request line so that transfers can stop once an interrupt is pending. The converters, the mixer and the DMA engine sit outside this block. The sample-position flags arrive as level inputs, and the end of a period arrives as a one-cycle strobe.

Top module: `codec_ctl`

## Requirements
- R1: The port is selected by `bus_addr`: 0 is the pointer port, 1 the window port, 2 the status port and 3 the polled port. A read puts its result on `bus_rdata` one clock after `bus_rd`, and `bus_rdata` holds its value while `bus_rd` is low. A pointer-port read returns busy in bit 7, the mode-change enable (MCE) in bit 6, transfer-request-disable (TRD) in bit 5 and the register number in bits 4:0. A pointer-port write loads bits 6:0 and ignores bit 7.
- R2: After reset is released, the busy flag stays set for `INIT_CYCLES` clocks (default 16) and then clears.
- R3: While `pwr_down` is high, the busy flag is set, starting one clock after `pwr_down` rises. The flag clears one clock after `pwr_down` falls.
- R4: While busy is set, a window-port read returns 0x80 and a window-port write leaves the registers unchanged.
- R5: Any register other than 8, 9 and 28 takes a window-port write whenever the block is not busy, and reads back what was written.
- R6: While MCE is clear, a window-port write to register 8 or 28 is dropped, and the register keeps its old value.
- R7: While MCE is clear, a write to register 9 changes only bits 1:0 (playback and capture enable). While MCE is set, all bits of registers 8, 9 and 28 are written.
- R8: `dac_mute` equals the MCE bit, and follows it one clock after a pointer-port write.
- R9: A status-port read returns `pos_flags[6:0]` in bits 7:1 and the interrupt-active flag in bit 0.
- R10: A `period_done` pulse sets the interrupt-active flag. Any status-port write clears it, whatever the data. If a clear and a set fall in the same cycle, the flag is set.
- R11: `dma_req_out` follows `dma_req_in` one clock later, except that it is low when TRD and the interrupt-active flag are both set.
- R12: `vol_mute` is bit 7 of register 6.
- R13: A polled-port read returns 0x00, and a polled-port write changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Port select |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| pwr_down | input | 1 | Software power-down request (level) |
| period_done | input | 1 | End-of-period pulse; sets the interrupt flag |
| pos_flags | input | 7 | Sample-position and ready flags, shown in status bits 7:1 |
| dma_req_in | input | 1 | Raw DMA request from the transfer logic |
| dma_req_out | output | 1 | Gated DMA request |
| dac_mute | output | 1 | DAC mute, active while MCE is set |
| vol_mute | output | 1 | Mute bit of the volume register |

## Verification
The assertions assume the host never raises `bus_rd` and `bus_wr` in the same cycle. They also assume `period_done` is a single-cycle pulse, so that a status-port write without a coincident pulse is expected to leave the flag low in the next cycle. The bench drives every bus access as an exclusive one-cycle strobe on the falling edge. It drops `period_done` after one cycle, and it applies the same-cycle collision only through a dedicated step that the clear-without-set property does not cover.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int DW = 8;
  localparam logic [1:0] PORT_PTR    = 2'd0;
  localparam logic [1:0] PORT_WIN    = 2'd1;
  localparam logic [1:0] PORT_STATUS = 2'd2;
  localparam logic [1:0] PORT_POLL   = 2'd3;
  localparam logic [DW-1:0] BUSY_READ = 8'h80;
  // bit positions inside the pointer port
  localparam int PTR_BUSY_BIT = 7;
  localparam int PTR_MCE_BIT  = 6;
  localparam int PTR_TRD_BIT  = 5;
  localparam int PTR_IDX_W    = 5;
endpackage

// File: rtl/ctl_busy_timer.sv
module ctl_busy_timer #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  output logic busy
);
  localparam int CW = $clog2(INIT_CYCLES + 2);
  logic [CW-1:0] cnt;
  logic          pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(INIT_CYCLES);
      pd_q <= 1'b0;
    end else begin
      pd_q <= pwr_down;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0) || pd_q;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int NUM_REGS  = 32,
  parameter int DW        = 8,
  parameter int FMT_IDX_A = 8,
  parameter int FMT_IDX_B = 28,
  parameter int IFC_IDX   = 9,
  parameter logic [DW-1:0] IFC_FREE = 8'h03,
  parameter int VOL_IDX   = 6,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          mce,
  output logic [DW-1:0] rd_word,
  output logic          vol_mute
);
  logic [DW-1:0] regs      [NUM_REGS];
  logic [DW-1:0] lock_mask [NUM_REGS];

  // bits that refuse writes while the mode-change enable is clear
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask
    if (i == FMT_IDX_A || i == FMT_IDX_B) begin : g_full
      assign lock_mask[i] = '1;
    end else if (i == IFC_IDX) begin : g_part
      assign lock_mask[i] = ~IFC_FREE;
    end else begin : g_open
      assign lock_mask[i] = '0;
    end
  end

  logic [DW-1:0] wmask;
  assign wmask = mce ? '1 : ~lock_mask[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
    end else if (we) begin
      regs[addr] <= (regs[addr] & ~wmask) | (wdata & wmask);
    end
  end

  assign rd_word  = regs[addr];
  assign vol_mute = regs[VOL_IDX][DW-1];
endmodule

// File: rtl/ctl_irq_flag.sv
module ctl_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)            irq <= 1'b0;
    else if (set_pulse) irq <= 1'b1;
    else if (clr)       irq <= 1'b0;
  end
endmodule

// File: rtl/codec_ctl.sv
module codec_ctl
  import codec_ctl_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int INIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       pwr_down,
  input  logic       period_done,
  input  logic [6:0] pos_flags,
  input  logic       dma_req_in,
  output logic       dma_req_out,
  output logic       dac_mute,
  output logic       vol_mute
);
  localparam int AW = $clog2(NUM_REGS);

  logic          busy;
  logic          mce_q, trd_q;
  logic [AW-1:0] idx_q;
  logic          irq_q;
  logic [DW-1:0] win_word;

  logic wr_ptr, wr_win, wr_status;
  assign wr_ptr    = bus_wr && (bus_addr == PORT_PTR);
  assign wr_win    = bus_wr && (bus_addr == PORT_WIN) && !busy;
  assign wr_status = bus_wr && (bus_addr == PORT_STATUS);

  ctl_busy_timer #(.INIT_CYCLES(INIT_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .busy(busy)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .we(wr_win), .addr(idx_q), .wdata(bus_wdata),
    .mce(mce_q), .rd_word(win_word), .vol_mute(vol_mute)
  );

  ctl_irq_flag u_irq (
    .clk(clk), .rst(rst), .set_pulse(period_done), .clr(wr_status), .irq(irq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mce_q <= 1'b0;
      trd_q <= 1'b0;
      idx_q <= '0;
    end else if (wr_ptr) begin
      mce_q <= bus_wdata[PTR_MCE_BIT];
      trd_q <= bus_wdata[PTR_TRD_BIT];
      idx_q <= bus_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        PORT_PTR:    bus_rdata <= {busy, mce_q, trd_q, PTR_IDX_W'(idx_q)};
        PORT_WIN:    bus_rdata <= busy ? BUSY_READ : win_word;
        PORT_STATUS: bus_rdata <= {pos_flags, irq_q};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dma_req_out <= 1'b0;
    else     dma_req_out <= dma_req_in && !(trd_q && irq_q);
  end

  assign dac_mute = mce_q;
endmodule

// File: rtl/codec_ctl_chk.sv
module codec_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       period_done,
  input logic       dma_req_in,
  input logic       dma_req_out,
  input logic       dac_mute,
  input logic       irq,
  input logic       trd,
  input logic       busy
);
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_busy_window_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1 && busy) |=> (bus_rdata == 8'h80));

  p_mute_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> (dac_mute == $past(bus_wdata[6])));

  p_irq_set_r10: assert property (@(posedge clk) disable iff (rst)
    period_done |=> irq);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && !period_done) |=> !irq);

  p_dma_block_r11: assert property (@(posedge clk) disable iff (rst)
    (trd && irq) |=> !dma_req_out);

  p_dma_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !dma_req_in |=> !dma_req_out);
endmodule

bind codec_ctl codec_ctl_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .period_done(period_done),
  .dma_req_in(dma_req_in), .dma_req_out(dma_req_out), .dac_mute(dac_mute),
  .irq(irq_q), .trd(trd_q), .busy(busy)
);

// File: tb/sim_codec_ctl.sv
module sim_codec_ctl;
  localparam int INIT = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic pwr_down = 0, period_done = 0, dma_req_in = 0;
  logic [6:0] pos_flags = 0;
  logic dma_req_out, dac_mute, vol_mute;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  codec_ctl #(.NUM_REGS(32), .INIT_CYCLES(INIT)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_down(pwr_down),
    .period_done(period_done), .pos_flags(pos_flags), .dma_req_in(dma_req_in),
    .dma_req_out(dma_req_out), .dac_mute(dac_mute), .vol_mute(vol_mute)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h expected=%02h", req, got, exp);
    end
  endtask

  // tasks begin and end on a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1; v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_period();
    period_done = 1;
    @(posedge clk); #1;
    @(negedge clk); period_done = 0;
  endtask

  function automatic void model_write(input int i, input logic [7:0] d, input logic m);
    if (m || !(i == 8 || i == 28 || i == 9)) model[i] = d;
    else if (i == 9) model[9] = {model[9][7:2], d[1:0]};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int nbusy;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R4: write during the initial busy period is ignored
    wr(2'd0, 8'h03);
    wr(2'd1, 8'hAB);
    // R2: busy lasts INIT clocks after reset (two already used)
    nbusy = 0;
    for (int k = 0; k < 40; k++) begin
      rd(2'd0, v);
      if (v[7]) nbusy++; else break;
    end
    check("R2 busy cycles", 8'(nbusy), 8'(INIT - 2));
    rd(2'd1, v);
    check("R4 write ignored while busy", v, 8'h00);
    check("R8 mute low after reset", {7'b0, dac_mute}, 8'h00);

    // R1: pointer readback, bit 7 ignored on write
    wr(2'd0, 8'hB4);
    rd(2'd0, v);
    check("R1 pointer readback", v, 8'h34);
    check("R11 dma idle", {7'b0, dma_req_out}, 8'h00);
    wr(2'd0, 8'h00);

    // R5 R6 R7: sweep all registers with MCE clear, then set
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 32; i++) begin
        logic [7:0] d;
        d = 8'(i * 37 + 8'h5B + pass * 8'h11);
        wr(2'd0, {1'b0, pass[0], 1'b0, 5'(i)});
        wr(2'd1, d);
        model_write(i, d, pass[0]);
      end
      check("R8 mute follows MCE", {7'b0, dac_mute}, {7'b0, pass[0]});
      for (int i = 0; i < 32; i++) begin
        wr(2'd0, {1'b0, pass[0], 1'b0, 5'(i)});
        rd(2'd1, v);
        check((i == 8 || i == 28) ? "R6 locked register" :
              (i == 9) ? "R7 interface register" : "R5 open register", v, model[i]);
      end
    end
    // R7: only enable bits move with MCE clear
    wr(2'd0, 8'h09);
    check("R8 mute clear", {7'b0, dac_mute}, 8'h00);
    wr(2'd1, 8'hFF); model_write(9, 8'hFF, 1'b0);
    rd(2'd1, v); check("R7 enable bits only", v, model[9]);
    wr(2'd1, 8'h00); model_write(9, 8'h00, 1'b0);
    rd(2'd1, v); check("R7 enable bits cleared", v, model[9]);

    // R12: volume mute bit
    wr(2'd0, 8'h06); wr(2'd1, 8'h80);
    check("R12 vol mute set", {7'b0, vol_mute}, 8'h01);
    wr(2'd1, 8'h7F);
    check("R12 vol mute clear", {7'b0, vol_mute}, 8'h00);
    model[6] = 8'h7F;

    // R3 R4: power-down busy
    wr(2'd0, 8'h03);
    pwr_down = 1;
    @(posedge clk); #1; @(negedge clk);
    rd(2'd0, v); check("R3 busy in power-down", v, 8'h83);
    wr(2'd1, 8'hEE);
    rd(2'd1, v); check("R4 busy read value", v, 8'h80);
    pwr_down = 0;
    @(posedge clk); #1; @(negedge clk);
    rd(2'd0, v); check("R3 busy released", v, 8'h03);
    rd(2'd1, v); check("R4 power-down write dropped", v, model[3]);

    // R9 R10: status port
    for (int f = 0; f < 128; f += 37) begin
      pos_flags = 7'(f);
      rd(2'd2, v); check("R9 status flags", v, {7'(f), 1'b0});
    end
    pulse_period();
    rd(2'd2, v); check("R10 irq set", v[0] ? 8'h01 : 8'h00, 8'h01);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R10 irq cleared by write", {7'b0, v[0]}, 8'h00);
    bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'hFF; period_done = 1;
    @(posedge clk); #1; @(negedge clk);
    bus_wr = 0; period_done = 0;
    rd(2'd2, v); check("R10 set wins over clear", {7'b0, v[0]}, 8'h01);
    wr(2'd2, 8'h5A);

    // R11: sweep TRD x irq x request
    for (int c = 0; c < 8; c++) begin
      logic t, q, r;
      t = c[2]; q = c[1]; r = c[0];
      wr(2'd2, 8'h00);
      wr(2'd0, {2'b00, t, 5'd0});
      if (q) pulse_period();
      dma_req_in = r;
      @(posedge clk); #1;
      check("R11 dma gate", {7'b0, dma_req_out}, {7'b0, r && !(t && q)});
      @(negedge clk); dma_req_in = 0;
    end

    // R13: polled port
    wr(2'd0, 8'h03);
    wr(2'd3, 8'hC3);
    rd(2'd3, v); check("R13 polled read zero", v, 8'h00);
    rd(2'd0, v); check("R13 pointer unchanged", v, 8'h03);
    rd(2'd1, v); check("R13 register unchanged", v, model[3]);

    finish_run();
  end
endmodule